// File: doc/BRIEF.md
# Double-Buffered Crosspoint Switch

This block is a non-blocking single-bit crosspoint with sixteen data inputs and sixteen data outputs. Every output has its own 16:1 selector, so one input can feed any number of outputs at once. The data path is combinational from `data_i` to `data_o`. Only the routing state is held in registers.

Routing is programmed in two stages. First, the block writes a staging register for one output per clock while `load_i` is high. `dst_addr_i` picks the output and `src_addr_i` gives the source input. Then `commit_i` copies every staging register into the live route registers in a single edge. Outputs whose source did not change keep carrying data across the commit without a gap.

A preset strobe overwrites both register banks with a fixed pattern. With `commit_i` low the pattern is broadcast: every output takes input 0. With `commit_i` high the pattern is pass-through: output k takes input k. `route_o` reports the live selection of every output.

Top module: `xbar_matrix`

## Requirements
- R1: Each output bit k equals `data_i` at the index held in the live route of output k. The same input may drive several outputs at once.
- R2: With `load_i` high and `preset_i` low, the clock edge writes `src_addr_i` into the staging register of output `dst_addr_i` only. At most one staging register is written per edge.
- R3: Staging writes never change `route_o` or `data_o` until a commit follows.
- R4: With `commit_i` high and `preset_i` low, all sixteen staging registers are copied into the live route registers on the same edge. The new routing appears on `route_o` right after that edge. `route_o[4k+3:4k]` holds the source index of output k.
- R5: Across a commit, an output whose selection is unchanged keeps the same value, provided its input does not change.
- R6: `preset_i` high with `commit_i` low loads input 0 into every staging register and every live route (broadcast).
- R7: `preset_i` high with `commit_i` high loads k into both the staging register and the live route of every output k (pass-through).
- R8: When `load_i` and `commit_i` are high on the same edge, the commit takes the staging contents from before that edge's write. The written value takes effect only at the next commit.
- R9: A commit after a preset, with no staging writes in between, keeps the preset routing.
- R10: During a preset, `load_i` is ignored. No staging register takes `src_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all route state |
| preset_i | input | 1 | Preset strobe that loads the broadcast or pass-through pattern |
| commit_i | input | 1 | Copies staging registers to live routes; during a preset, selects pass-through |
| load_i | input | 1 | Staging-register write enable |
| src_addr_i | input | 4 | Source input index to be written |
| dst_addr_i | input | 4 | Output whose staging register is written |
| data_i | input | 16 | Data inputs |
| data_o | output | 16 | Data outputs |
| route_o | output | 64 | Live source index of each output, 4 bits per output |

## Verification
The stimulus table programs a permutation in which each output takes a different source. That routing is then driven with every one-hot input word and with two mixed words. One-hot words expose any output wired to the wrong source. Mixed words expose polarity and fan-out errors.

Directed cases target the staging-to-live boundary:
- a load with no commit, to show the live routing holds;
- a load and a commit on the same edge, to show the commit copies the old staging value;
- a preset with load high, to show the load is ignored;
- a commit with no loads after each kind of preset, to show the preset pattern is kept.

Output bits that are not reprogrammed are compared across a commit to show they do not glitch.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  // Source index that a preset assigns to output k.
  function automatic int unsigned preset_src(int unsigned k, logic pass);
    return pass ? k : 0;
  endfunction
endpackage

// File: rtl/xbar_prog_bank.sv
module xbar_prog_bank #(
  parameter int N_PORTS = 16,
  parameter int SEL_W   = $clog2(N_PORTS)
) (
  input  logic                       clk,
  input  logic                       preset_i,
  input  logic                       pass_i,
  input  logic                       load_i,
  input  logic [SEL_W-1:0]           dst_i,
  input  logic [SEL_W-1:0]           src_i,
  output logic [N_PORTS-1:0]         wr_en_o,
  output logic [N_PORTS*SEL_W-1:0]   prog_o
);
  always_comb begin
    for (int i = 0; i < N_PORTS; i++)
      wr_en_o[i] = load_i && !preset_i && (dst_i == SEL_W'(i));
  end

  for (genvar g = 0; g < N_PORTS; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (preset_i)
        prog_o[g*SEL_W +: SEL_W] <= SEL_W'(xbar_pkg::preset_src(g, pass_i));
      else if (wr_en_o[g])
        prog_o[g*SEL_W +: SEL_W] <= src_i;
    end
  end
endmodule

// File: rtl/xbar_cfg_bank.sv
module xbar_cfg_bank #(
  parameter int N_PORTS = 16,
  parameter int SEL_W   = $clog2(N_PORTS)
) (
  input  logic                       clk,
  input  logic                       preset_i,
  input  logic                       pass_i,
  input  logic                       commit_i,
  input  logic [N_PORTS*SEL_W-1:0]   prog_i,
  output logic [N_PORTS*SEL_W-1:0]   route_o
);
  for (genvar g = 0; g < N_PORTS; g++) begin : g_live
    always_ff @(posedge clk) begin
      if (preset_i)
        route_o[g*SEL_W +: SEL_W] <= SEL_W'(xbar_pkg::preset_src(g, pass_i));
      else if (commit_i)
        route_o[g*SEL_W +: SEL_W] <= prog_i[g*SEL_W +: SEL_W];
    end
  end
endmodule

// File: rtl/xbar_mux_col.sv
module xbar_mux_col #(
  parameter int N_PORTS = 16,
  parameter int SEL_W   = $clog2(N_PORTS)
) (
  input  logic [N_PORTS-1:0] data_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               bit_o
);
  always_comb begin
    bit_o = 1'b0;
    for (int i = 0; i < N_PORTS; i++)
      if (sel_i == SEL_W'(i)) bit_o = data_i[i];
  end
endmodule

// File: rtl/xbar_matrix.sv
module xbar_matrix #(
  parameter int N_PORTS = 16,
  parameter int SEL_W   = $clog2(N_PORTS)
) (
  input  logic                     clk,
  input  logic                     preset_i,
  input  logic                     commit_i,
  input  logic                     load_i,
  input  logic [SEL_W-1:0]         src_addr_i,
  input  logic [SEL_W-1:0]         dst_addr_i,
  input  logic [N_PORTS-1:0]       data_i,
  output logic [N_PORTS-1:0]       data_o,
  output logic [N_PORTS*SEL_W-1:0] route_o
);
  logic [N_PORTS-1:0]       wr_en;
  logic [N_PORTS*SEL_W-1:0] prog_flat;
  logic                     commit_fire;

  assign commit_fire = commit_i && !preset_i;

  xbar_prog_bank #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_prog (
    .clk(clk), .preset_i(preset_i), .pass_i(commit_i), .load_i(load_i),
    .dst_i(dst_addr_i), .src_i(src_addr_i), .wr_en_o(wr_en), .prog_o(prog_flat)
  );

  xbar_cfg_bank #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_cfg (
    .clk(clk), .preset_i(preset_i), .pass_i(commit_i), .commit_i(commit_fire),
    .prog_i(prog_flat), .route_o(route_o)
  );

  for (genvar g = 0; g < N_PORTS; g++) begin : g_col
    xbar_mux_col #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_mux (
      .data_i(data_i), .sel_i(route_o[g*SEL_W +: SEL_W]), .bit_o(data_o[g])
    );
  end
endmodule

// File: rtl/xbar_matrix_chk.sv
module xbar_matrix_chk #(
  parameter int N_PORTS = 16,
  parameter int SEL_W   = $clog2(N_PORTS)
) (
  input logic                     clk,
  input logic                     preset_i,
  input logic                     commit_i,
  input logic                     load_i,
  input logic [N_PORTS*SEL_W-1:0] route_o,
  input logic [N_PORTS*SEL_W-1:0] prog_flat,
  input logic [N_PORTS-1:0]       wr_en,
  input logic                     commit_fire
);
  function automatic logic [N_PORTS*SEL_W-1:0] ident_map();
    logic [N_PORTS*SEL_W-1:0] v;
    for (int i = 0; i < N_PORTS; i++) v[i*SEL_W +: SEL_W] = SEL_W'(i);
    return v;
  endfunction
  localparam logic [N_PORTS*SEL_W-1:0] IDENT = ident_map();

  logic armed = 1'b0;
  always_ff @(posedge clk) if (preset_i) armed <= 1'b1;

  // R2: one staging register per edge at most
  a_r2_single_write: assert property (@(posedge clk) disable iff (!armed)
    $onehot0(wr_en));
  // R10: no staging write during preset
  a_r10_preset_blocks_load: assert property (@(posedge clk) disable iff (!armed)
    (preset_i && load_i) |-> (wr_en == '0));
  // R3: routing holds without commit or preset
  a_r3_route_holds: assert property (@(posedge clk) disable iff (!armed)
    (!commit_i && !preset_i) |=> $stable(route_o));
  // R4: commit copies all staging registers at once
  a_r4_commit_copies: assert property (@(posedge clk) disable iff (!armed)
    commit_fire |=> (route_o == $past(prog_flat)));
  // R6: broadcast preset
  a_r6_broadcast: assert property (@(posedge clk) disable iff (!armed)
    (preset_i && !commit_i) |=> (route_o == '0 && prog_flat == '0));
  // R7: pass-through preset
  a_r7_passthru: assert property (@(posedge clk) disable iff (!armed)
    (preset_i && commit_i) |=> (route_o == IDENT && prog_flat == IDENT));
endmodule

bind xbar_matrix xbar_matrix_chk #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .preset_i(preset_i), .commit_i(commit_i), .load_i(load_i),
  .route_o(route_o), .prog_flat(prog_flat), .wr_en(wr_en), .commit_fire(commit_fire)
);

// File: tb/xbar_matrix_bench.sv
`timescale 1ns/1ps
module xbar_matrix_bench;
  localparam int N = 16;
  localparam int W = 4;

  logic clk = 1'b0;
  logic preset_i = 1'b0, commit_i = 1'b0, load_i = 1'b0;
  logic [W-1:0] src_addr_i = '0, dst_addr_i = '0;
  logic [N-1:0] data_i = '0;
  logic [N-1:0] data_o;
  logic [N*W-1:0] route_o;

  int tests = 0, fails = 0;
  logic [W-1:0] m_prog [N];
  logic [W-1:0] m_live [N];

  always #4 clk = ~clk;

  xbar_matrix u_xbar_matrix (
    .clk(clk), .preset_i(preset_i), .commit_i(commit_i), .load_i(load_i),
    .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i), .data_i(data_i),
    .data_o(data_o), .route_o(route_o)
  );

  // {dst, src}: output i takes input (7*i+3) mod 16
  localparam logic [7:0] PLAN [16] = '{
    8'h03, 8'h1A, 8'h21, 8'h38, 8'h4F, 8'h56, 8'h6D, 8'h74,
    8'h8B, 8'h92, 8'hA9, 8'hB0, 8'hC7, 8'hDE, 8'hE5, 8'hFC};

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // model update for one edge, following R2/R4/R6/R7/R8/R10
  task automatic model_edge();
    logic [W-1:0] snap [N];
    for (int i = 0; i < N; i++) snap[i] = m_prog[i];
    if (preset_i) begin
      for (int i = 0; i < N; i++) begin
        m_prog[i] = commit_i ? W'(i) : '0;
        m_live[i] = m_prog[i];
      end
    end else begin
      if (load_i) m_prog[dst_addr_i] = src_addr_i;
      if (commit_i) for (int i = 0; i < N; i++) m_live[i] = snap[i];
    end
  endtask

  task automatic step();
    model_edge();
    tick();
  endtask

  function automatic logic [N*W-1:0] model_route();
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = m_live[i];
    return v;
  endfunction

  function automatic logic [N-1:0] model_data(logic [N-1:0] d);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = d[m_live[i]];
    return v;
  endfunction

  task automatic chk_route(string req);
    tests++;
    if (route_o !== model_route()) begin
      fails++;
      $display("FAIL %s route actual=%h expected=%h", req, route_o, model_route());
    end
  endtask

  task automatic chk_data(string req, logic [N-1:0] d);
    data_i = d; #1;
    tests++;
    if (data_o !== model_data(d)) begin
      fails++;
      $display("FAIL %s data in=%h actual=%h expected=%h", req, d, data_o, model_data(d));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] keep;
    #1;
    // R6: broadcast preset
    preset_i = 1; commit_i = 0; step();
    preset_i = 0;
    chk_route("R6");
    chk_data("R6", 16'h0001);
    chk_data("R6", 16'hFFFE);

    // R2 / R3: stage the whole plan without commit
    for (int v = 0; v < 16; v++) begin
      load_i = 1; dst_addr_i = PLAN[v][7:4]; src_addr_i = PLAN[v][3:0];
      step();
      chk_route("R3");
    end
    load_i = 0;
    chk_data("R3", 16'h0001);

    // R4: commit everything at once
    commit_i = 1; step(); commit_i = 0;
    chk_route("R4");

    // R1: one-hot and mixed words through the permutation
    for (int b = 0; b < N; b++) chk_data("R1", N'(1) << b);
    chk_data("R1", 16'hA5C3);
    chk_data("R1", 16'h5A3C);

    // R2: rewrite only output 7, commit, others unchanged
    load_i = 1; dst_addr_i = 4'd7; src_addr_i = 4'd0; step(); load_i = 0;
    chk_route("R2");
    // R5: hold data steady across the commit; outputs other than 7 keep value
    data_i = 16'h00FF; #1;
    keep = data_o;
    commit_i = 1; step(); commit_i = 0;
    tests++;
    if ((data_o & ~16'h0080) !== (keep & ~16'h0080)) begin
      fails++;
      $display("FAIL R5 actual=%h expected=%h", data_o & ~16'h0080, keep & ~16'h0080);
    end
    chk_route("R2");
    chk_data("R1", 16'h0001);

    // R7 / R9: pass-through preset then commit with no loads
    preset_i = 1; commit_i = 1; step(); preset_i = 0; commit_i = 0;
    chk_route("R7");
    chk_data("R7", 16'h8421);
    commit_i = 1; step(); commit_i = 0;
    chk_route("R9");

    // R8: load and commit on the same edge
    load_i = 1; commit_i = 1; dst_addr_i = 4'd2; src_addr_i = 4'd9; step();
    load_i = 0; commit_i = 0;
    tests++;
    if (route_o[2*W +: W] !== 4'd2) begin
      fails++;
      $display("FAIL R8 route2 actual=%0d expected=2", route_o[2*W +: W]);
    end
    commit_i = 1; step(); commit_i = 0;
    tests++;
    if (route_o[2*W +: W] !== 4'd9) begin
      fails++;
      $display("FAIL R8 route2 actual=%0d expected=9", route_o[2*W +: W]);
    end

    // R10: preset with load high ignores the load
    preset_i = 1; commit_i = 0; load_i = 1; dst_addr_i = 4'd5; src_addr_i = 4'd11; step();
    preset_i = 0; load_i = 0;
    commit_i = 1; step(); commit_i = 0;
    chk_route("R10");
    tests++;
    if (route_o[5*W +: W] !== 4'd0) begin
      fails++;
      $display("FAIL R10 route5 actual=%0d expected=0", route_o[5*W +: W]);
    end
    chk_route("R9");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule